// File: doc/BRIEF.md
# USB transmit bit serializer

This block turns outgoing packet bytes into the serial bit stream for a USB line. The link offers bytes one at a time with a valid flag and a last-byte flag. The block acknowledges each byte with a one-cycle `nxt` pulse. The first byte of a packet is the transmit command (the PID). It is accepted while the line is still idle. After it is taken, the block sends a synchronization pattern, then the bytes least-significant bit first. A zero is inserted after every run of ones that reaches the stuffing limit. The whole stuffed stream is NRZI-coded, and the packet ends with an end-of-packet signature, after which the line driver is released.

All line activity moves on a one-bit-time clock enable, `bit_en`, which is high for one clock per bit slot. Ticks must be at least four clocks apart. A new byte is requested only once the shift register is empty and the next slot is a data slot. A stuff bit therefore delays the request by one bit time, and the rate at which bytes are taken is not fixed. The link keeps `tx_valid` high and its data steady until it sees `nxt`.

Top module: `usb_tx_serializer`

## Requirements
- R1: While reset is high, and after it until the first packet, `line_dp` is 1 (J), `line_se0` is 0, `line_oe` is 0 and `nxt` is 0.
- R2: `nxt` is high for exactly one clock per byte. The byte, together with `tx_last`, is taken on the rising edge at which `nxt` is high. The first byte of a packet is requested while the line is idle, before any sync slot.
- R3: After the first byte is accepted, the next eight bit slots carry the sync pattern 8'b1000_0000 sent LSB first (seven raw zeros, then a raw one). `line_oe` goes high in the first sync slot.
- R4: Data bytes follow the sync in the order accepted, each sent least-significant bit first.
- R5: After six consecutive raw one bits, a raw zero is inserted. The final one of the sync counts toward the run, and so do ones that span a byte boundary. A stuff bit clears the run. A stuff bit that is due after the last data bit is still sent before the end of packet.
- R6: NRZI coding: a raw zero (data, sync or stuff) toggles `line_dp`, and a raw one leaves it unchanged. The line starts every packet from J (1).
- R7: Byte k (k of 1 or more) is requested only after the slot that carries the last bit of byte k-1, and after the stuff slot that follows it when one is due. The request comes before the next bit slot.
- R8: After the last data slot (plus any stuff slot), two slots have `line_se0`=1 and `line_dp`=0. Then one slot has `line_dp`=1, `line_se0`=0 and `line_oe`=1. In the following slot `line_oe` falls with `line_dp`=1.
- R9: `line_dp`, `line_se0` and `line_oe` change only on clock edges at which `bit_en` is high.
- R10: `nxt` stays low from the first sync slot to the end of the packet except for data-byte requests. A link that offers a new packet during an end of packet is not acknowledged until `line_oe` has fallen.
- R11: The byte flagged by `tx_last` is the final byte of the packet, and a one-byte packet is sent as sync, that byte and the end of packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-bit-time enable, one clock per bit slot |
| tx_valid | input | 1 | Link offers a byte |
| tx_data | input | DATA_W | Offered byte |
| tx_last | input | 1 | Offered byte is the last of its packet |
| nxt | output | 1 | Byte acknowledge, one clock per accepted byte |
| line_dp | output | 1 | NRZI-coded line bit (1 = J) |
| line_se0 | output | 1 | Single-ended zero on the line |
| line_oe | output | 1 | Line driver enable |

## Verification
Two pairs of functions can fall on the same bit slot. A stuff bit can land on a byte boundary, where it competes with the request for the next byte. A stuff bit can also fall after the last data bit, where it competes with the start of the end of packet. Both are provoked with bytes whose upper bits are ones (0xFC, 0xFF, 0x7E), with a PID that completes a run begun by the sync's final one, and with a new packet offered during the previous end of packet. The behavioural model predicts the line level for every clock and the bit slot after which each `nxt` must appear, so an early request or a misplaced stuff bit shows up as a mismatch.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [2:0] {
    SYM_HOLD,
    SYM_IDLE,
    SYM_ZERO,
    SYM_ONE,
    SYM_SE0,
    SYM_J
  } sym_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_EOPSE0,
    ST_EOPJ,
    ST_OFF
  } st_e;

endpackage

// File: rtl/usb_tx_byte_port.sv
module usb_tx_byte_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         want,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  input  logic         tx_last,
  output logic         nxt,
  output logic         load,
  output logic [W-1:0] ld_data,
  output logic         ld_last
);

  logic nxt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_q <= 1'b0;
    end else begin
      nxt_q <= want && tx_valid && !nxt_q;
    end
  end

  assign nxt     = nxt_q;
  assign load    = nxt_q && tx_valid;
  assign ld_data = tx_data;
  assign ld_last = tx_last;

endmodule

// File: rtl/usb_tx_shifter.sv
module usb_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         shift,
  output logic         cur_bit,
  output logic         empty
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= ld_data;
      cnt <= CW'(W);
    end else if (shift && cnt != '0) begin
      sh  <= {1'b0, sh[W-1:1]};
      cnt <= cnt - CW'(1);
    end
  end

  assign cur_bit = sh[0];
  assign empty   = (cnt == '0);

endmodule

// File: rtl/usb_tx_stuff_cnt.sv
module usb_tx_stuff_cnt #(
  parameter int RUN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step_en,
  input  logic step_bit,
  output logic stuff_due
);

  localparam int RW = $clog2(RUN + 1);

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run <= '0;
    end else if (step_en) begin
      run <= step_bit ? run + RW'(1) : '0;
    end
  end

  assign stuff_due = (run == RW'(RUN));

endmodule

// File: rtl/usb_tx_line_enc.sv
module usb_tx_line_enc
  import usb_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  sym_e sym,
  output logic line_dp,
  output logic line_se0,
  output logic line_oe
);

  logic lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl      <= 1'b1;
      line_dp  <= 1'b1;
      line_se0 <= 1'b0;
      line_oe  <= 1'b0;
    end else if (tick) begin
      case (sym)
        SYM_IDLE: begin
          lvl      <= 1'b1;
          line_dp  <= 1'b1;
          line_se0 <= 1'b0;
          line_oe  <= 1'b0;
        end
        SYM_ZERO: begin
          lvl      <= ~lvl;
          line_dp  <= ~lvl;
          line_se0 <= 1'b0;
          line_oe  <= 1'b1;
        end
        SYM_ONE: begin
          line_dp  <= lvl;
          line_se0 <= 1'b0;
          line_oe  <= 1'b1;
        end
        SYM_SE0: begin
          line_dp  <= 1'b0;
          line_se0 <= 1'b1;
          line_oe  <= 1'b1;
        end
        SYM_J: begin
          lvl      <= 1'b1;
          line_dp  <= 1'b1;
          line_se0 <= 1'b0;
          line_oe  <= 1'b1;
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
  import usb_tx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SYNC_BITS    = 8,
  parameter int STUFF_RUN    = 6,
  parameter int EOP_SE0_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_last,
  output logic              nxt,
  output logic              line_dp,
  output logic              line_se0,
  output logic              line_oe
);

  localparam int SYNC_W = $clog2(SYNC_BITS);
  localparam int EOP_W  = $clog2(EOP_SE0_BITS + 1);

  st_e               st;
  logic [SYNC_W-1:0] sync_cnt;
  logic [EOP_W-1:0]  se0_cnt;
  logic              last_q;

  logic              want;
  logic              load;
  logic [DATA_W-1:0] ld_data;
  logic              ld_last;
  logic              cur_bit;
  logic              empty;
  logic              shift;
  logic              stuff_due;
  logic              step_en;
  logic              step_bit;
  logic              clr_run;
  sym_e              sym;

  usb_tx_byte_port #(.W(DATA_W)) u_port (
    .clk      (clk),
    .rst      (rst),
    .want     (want),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .nxt      (nxt),
    .load     (load),
    .ld_data  (ld_data),
    .ld_last  (ld_last)
  );

  usb_tx_shifter #(.W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .ld_data (ld_data),
    .shift   (shift),
    .cur_bit (cur_bit),
    .empty   (empty)
  );

  usb_tx_stuff_cnt #(.RUN(STUFF_RUN)) u_stuff (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_run),
    .step_en   (step_en),
    .step_bit  (step_bit),
    .stuff_due (stuff_due)
  );

  usb_tx_line_enc u_line (
    .clk      (clk),
    .rst      (rst),
    .tick     (bit_en),
    .sym      (sym),
    .line_dp  (line_dp),
    .line_se0 (line_se0),
    .line_oe  (line_oe)
  );

  always_comb begin
    sym      = SYM_HOLD;
    shift    = 1'b0;
    step_en  = 1'b0;
    step_bit = 1'b0;
    want     = 1'b0;
    clr_run  = 1'b0;
    case (st)
      ST_IDLE: begin
        sym     = SYM_IDLE;
        want    = 1'b1;
        clr_run = 1'b1;
      end
      ST_SYNC: begin
        step_en = bit_en;
        if (sync_cnt == SYNC_W'(SYNC_BITS - 1)) begin
          sym      = SYM_ONE;
          step_bit = 1'b1;
        end else begin
          sym = SYM_ZERO;
        end
      end
      ST_DATA: begin
        want = empty && !stuff_due && !last_q;
        if (stuff_due) begin
          sym     = SYM_ZERO;
          step_en = bit_en;
        end else if (!empty) begin
          sym      = cur_bit ? SYM_ONE : SYM_ZERO;
          shift    = bit_en;
          step_en  = bit_en;
          step_bit = cur_bit;
        end else if (last_q) begin
          sym = SYM_SE0;
        end
      end
      ST_EOPSE0: sym = SYM_SE0;
      ST_EOPJ:   sym = SYM_J;
      ST_OFF:    sym = SYM_IDLE;
      default:   sym = SYM_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sync_cnt <= '0;
      se0_cnt  <= '0;
      last_q   <= 1'b0;
    end else begin
      if (load) begin
        last_q <= ld_last;
      end
      case (st)
        ST_IDLE: begin
          if (load) begin
            st       <= ST_SYNC;
            sync_cnt <= '0;
          end
        end
        ST_SYNC: begin
          if (bit_en) begin
            if (sync_cnt == SYNC_W'(SYNC_BITS - 1)) begin
              st <= ST_DATA;
            end else begin
              sync_cnt <= sync_cnt + SYNC_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (bit_en && !stuff_due && empty && last_q) begin
            se0_cnt <= EOP_W'(1);
            st      <= (EOP_SE0_BITS == 1) ? ST_EOPJ : ST_EOPSE0;
          end
        end
        ST_EOPSE0: begin
          if (bit_en) begin
            se0_cnt <= se0_cnt + EOP_W'(1);
            if (se0_cnt == EOP_W'(EOP_SE0_BITS - 1)) begin
              st <= ST_EOPJ;
            end
          end
        end
        ST_EOPJ: if (bit_en) st <= ST_OFF;
        ST_OFF:  if (bit_en) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb_tx_serializer_chk.sv
module usb_tx_serializer_chk #(
  parameter int STUFF_RUN = 6
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic nxt,
  input logic line_dp,
  input logic line_se0,
  input logic line_oe
);

  logic       tk_q;
  logic       have_prev;
  logic       prev_dp;
  logic [7:0] hold_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      tk_q      <= 1'b0;
      have_prev <= 1'b0;
      prev_dp   <= 1'b1;
      hold_run  <= '0;
    end else begin
      tk_q <= bit_en;
      if (tk_q) begin
        if (line_oe && !line_se0) begin
          if (have_prev && line_dp == prev_dp) hold_run <= hold_run + 8'd1;
          else hold_run <= '0;
          have_prev <= 1'b1;
          prev_dp   <= line_dp;
        end else begin
          have_prev <= 1'b0;
          hold_run  <= '0;
        end
      end
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst) !bit_en |=> $stable({line_dp, line_se0, line_oe})); // R9
  AST_NXT_SINGLE: assert property (@(posedge clk) disable iff (rst) nxt |=> !nxt); // R2
  AST_NO_NXT_IN_EOP: assert property (@(posedge clk) disable iff (rst) line_se0 |-> !nxt); // R10
  AST_SYNC_K: assert property (@(posedge clk) disable iff (rst) $rose(line_oe) |-> !line_dp); // R3
  AST_EOP_TAIL: assert property (@(posedge clk) disable iff (rst) $fell(line_oe) |-> (line_dp && $past(line_dp && !line_se0))); // R8
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst) hold_run <= 8'(STUFF_RUN)); // R5

endmodule

bind usb_tx_serializer usb_tx_serializer_chk #(.STUFF_RUN(STUFF_RUN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_en   (bit_en),
  .nxt      (nxt),
  .line_dp  (line_dp),
  .line_se0 (line_se0),
  .line_oe  (line_oe)
);

// File: tb/sim_usb_tx_serializer.sv
module sim_usb_tx_serializer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_last = 1'b0;
  logic       nxt, line_dp, line_se0, line_oe;

  usb_tx_serializer u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .nxt(nxt),
    .line_dp(line_dp), .line_se0(line_se0), .line_oe(line_oe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int gap_a = 5;
  int gap_b = 5;
  int cyc = 0;

  // symbols: 0 data0, 1 data1, 2 se0, 3 J, 4 off, 5 stuff0, 6 sync0, 7 sync1
  int   sq[$];
  int   pend[$];
  int   nx_exp[$];
  logic [7:0] pkt[$];
  int   pops = 0;
  int   nb = 0;
  logic m_lvl = 1'b1, m_dp = 1'b1, m_se0 = 1'b0, m_oe = 1'b0;
  string m_tag = "R1";
  logic s_nxt = 1'b0;
  logic tick_prev = 1'b0;
  logic [2:0] prev_out = 3'b100;

  initial begin
    forever begin
      repeat (gap_a - 1) @(negedge clk);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      repeat (gap_b - 1) @(negedge clk);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
  end

  always @(posedge clk) begin
    int s;
    tick_prev = bit_en && !rst;
    if (rst) begin
      m_lvl = 1'b1; m_dp = 1'b1; m_se0 = 1'b0; m_oe = 1'b0;
      sq.delete();
      pops = 0;
      m_tag = "R1";
    end else begin
      if (bit_en && sq.size() > 0) begin
        s = sq.pop_front();
        pops++;
        case (s)
          0, 5, 6: begin m_lvl = ~m_lvl; m_dp = m_lvl; m_se0 = 1'b0; m_oe = 1'b1; end
          1, 7:    begin m_dp = m_lvl; m_se0 = 1'b0; m_oe = 1'b1; end
          2:       begin m_dp = 1'b0; m_se0 = 1'b1; m_oe = 1'b1; end
          3:       begin m_lvl = 1'b1; m_dp = 1'b1; m_se0 = 1'b0; m_oe = 1'b1; end
          default: begin m_lvl = 1'b1; m_dp = 1'b1; m_se0 = 1'b0; m_oe = 1'b0; end
        endcase
        case (s)
          0, 1:    m_tag = "R4";
          5:       m_tag = "R5";
          6, 7:    m_tag = "R3";
          default: m_tag = "R8";
        endcase
        if (sq.size() == 0) begin
          pops = 0;
          m_tag = "R10";
        end
      end
      if (s_nxt && tx_valid && sq.size() == 0 && !m_oe) begin
        foreach (pend[i]) sq.push_back(pend[i]);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (line_dp !== m_dp || line_se0 !== m_se0 || line_oe !== m_oe) begin
        fails++;
        $display("FAIL %s (NRZI R6) line dp/se0/oe actual %b%b%b expected %b%b%b",
                 m_tag, line_dp, line_se0, line_oe, m_dp, m_se0, m_oe);
      end
      checks++;
      if ({line_dp, line_se0, line_oe} !== prev_out && !tick_prev) begin
        fails++;
        $display("FAIL R9 line changed without bit_en: actual %b expected %b",
                 {line_dp, line_se0, line_oe}, prev_out);
      end
      if (nxt) begin
        checks++;
        if (nb >= nx_exp.size()) begin
          fails++;
          $display("FAIL R2 unexpected nxt: byte index %0d, expected at most %0d bytes", nb, nx_exp.size());
        end else if (pops != nx_exp[nb]) begin
          fails++;
          $display("FAIL %s nxt for byte %0d after slot %0d, expected after slot %0d",
                   (nb == 0) ? "R10" : "R7", nb, pops, nx_exp[nb]);
        end
        nb++;
      end
    end
    prev_out = {line_dp, line_se0, line_oe};
    s_nxt = nxt;
  end

  task automatic build();
    int run;
    pend.delete();
    nx_exp.delete();
    nx_exp.push_back(0);
    for (int i = 0; i < 7; i++) pend.push_back(6);
    pend.push_back(7);
    run = 1;
    for (int k = 0; k < pkt.size(); k++) begin
      for (int i = 0; i < 8; i++) begin
        int b;
        b = (pkt[k] >> i) & 1;
        pend.push_back(b);
        run = (b == 1) ? run + 1 : 0;
        if (run == 6) begin
          pend.push_back(5);
          run = 0;
        end
      end
      if (k < pkt.size() - 1) nx_exp.push_back(pend.size());
    end
    pend.push_back(2);
    pend.push_back(2);
    pend.push_back(3);
    pend.push_back(4);
  endtask

  task automatic send_pkt(input bit wait_done);
    build();
    nb = 0;
    for (int k = 0; k < pkt.size(); k++) begin
      tx_data  = pkt[k];
      tx_last  = (k == pkt.size() - 1);
      tx_valid = 1'b1;
      do @(negedge clk); while (!nxt);
      @(posedge clk);
      @(negedge clk);
    end
    tx_valid = 1'b0;
    tx_last  = 1'b0;
    if (wait_done) begin
      for (int i = 0; i < 2000; i++) begin
        if (sq.size() == 0 && !m_oe && !line_oe) break;
        @(negedge clk);
      end
      checks++;
      if (nb != pkt.size() || line_oe !== 1'b0 || line_dp !== 1'b1) begin
        fails++;
        $display("FAIL R11 packet end: bytes taken %0d expected %0d, oe/dp actual %b%b expected 01",
                 nb, pkt.size(), line_oe, line_dp);
      end
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (line_dp !== 1'b1 || line_se0 !== 1'b0 || line_oe !== 1'b0 || nxt !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state actual dp/se0/oe/nxt %b%b%b%b expected 1000",
               line_dp, line_se0, line_oe, nxt);
    end
    rst = 1'b0;
    repeat (12) @(negedge clk);

    pkt = '{8'hA5};                       send_pkt(1'b1); // R11 one byte
    pkt = '{8'hC3, 8'h01, 8'h80};         send_pkt(1'b1); // R4 bit order
    pkt = '{8'hFF, 8'hFF, 8'hFF};         send_pkt(1'b1); // R5 runs across bytes
    pkt = '{8'h1F, 8'hFC, 8'h3F};         send_pkt(1'b1); // R5 sync one counted, R7 stuff at boundary
    pkt = '{8'h2D, 8'hFC};                send_pkt(1'b1); // R5 stuff before EOP, R8
    gap_a = 4;
    gap_b = 7;
    pkt = '{8'h69, 8'h7E, 8'hFE, 8'h00};  send_pkt(1'b0); // R7 irregular bit timing
    pkt = '{8'hE1, 8'hFF};                send_pkt(1'b1); // R10 offered during EOP
    repeat (60) @(negedge clk);           // R1 R9 idle line

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL R2 watchdog: handshake or packet hung after %0d cycles, expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

endmodule